// File: doc/BRIEF.md
# SDRAM Mode-Register Command Issuer

This block sits in front of a DDR-type SDRAM controller and turns software register writes into single SDRAM commands. Software first writes a 3-bit command mode into a control register. The block does nothing at that point. The next write access that arrives on the memory-access stream is then consumed as a trigger, and the block places exactly one command on the SDRAM command bus in the following cycle. The access data is discarded. Bank and row bits for the command come from the address of that triggering write. The mode stays armed, so every further write fires the same command again until software changes the mode.

In normal mode (mode 0) the access stream passes straight through to a stub memory over a valid/ready handshake. A programmable refresh timer issues auto-refresh commands at a fixed cycle interval. Reads always pass through, whatever the mode. The SDRAM clock-enable output stays low after reset and goes high with the first NOP command the block issues.

Back-pressure rules on the access stream: an access is transferred on a cycle where `acc_valid` and `acc_ready` are both high. The initiator holds `acc_valid`, `acc_write` and `acc_addr` stable until that cycle. A command-mode write is accepted in the same cycle it is presented. A forwarded access takes its ready from `mem_ready`. On a cycle where a refresh fires, `acc_ready` is low.

Top module: `sdcmd_issuer`

## Requirements
- R1: After reset, the command bus is deselected (cs_n, ras_n, cas_n, we_n all 1), `sd_clk_en` is 0, the mode is 0 and the refresh interval is 0.
- R2: The mode field is `cfg_wdata[2:0]`, written when `cfg_we`=1 and `cfg_sel`=0. The mode codes and the commands they issue, as {cs_n,ras_n,cas_n,we_n}, are: 1 = NOP 0111; 2 = precharge-all 0010 with `sd_a[10]`=1; 4 = auto-refresh 0001; 3 and 5 = load-mode 0000. NOP, precharge and auto-refresh drive `sd_ba`=0. NOP and auto-refresh drive `sd_a`=0, and precharge drives `sd_a`=0x400.
- R3: In a mode other than 0, a write accepted on the access stream gives `acc_ready`=1 in the same cycle and `mem_valid`=0. It produces exactly one command cycle, visible one clock after the accepting edge.
- R4: The mode persists after a command fires: each further write in the same mode fires the same command again.
- R5: `sd_clk_en` stays 0 until the first NOP command appears on the bus. It rises in that cycle and never falls again until reset.
- R6: Mode 3 fires only when the access bank bits are 00, and mode 5 only when they are 10. The command then carries the bank bits on `sd_ba` and the row field on `sd_a`. A write with any other bank value is accepted but issues no command.
- R7: The access address is a byte address on a 16-bit bus: bit 0 is the byte lane, bits [9:1] the column, bits [21:10] the row and bits [23:22] the bank. Offset 0x800000 therefore gives bank 10.
- R8: In mode 0 a write is forwarded: `mem_valid`=`acc_valid`, `acc_ready`=`mem_ready`, and `mem_addr`/`mem_write` equal the access fields. No command is issued.
- R9: A read access (`acc_write`=0) is forwarded to the memory in every mode and issues no command.
- R10: The refresh interval is `cfg_wdata` written with `cfg_sel`=1. When it is N>0 and the mode is 0, auto-refresh appears every N cycles, the first one N cycles after the interval write or after the edge that writes mode 0. With N=0, or any mode other than 0, no refresh is issued.
- R11: During the cycle in which a refresh fires, `acc_ready` and `mem_valid` are both 0.
- R12: Modes 6 and 7 are reserved: a write is accepted and no command is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 1 | 0 selects the mode register, 1 selects the refresh interval |
| cfg_wdata | input | 16 | Control register write data |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access accepted |
| acc_write | input | 1 | 1 for a write access, 0 for a read access |
| acc_addr | input | 24 | Byte address of the access within the memory window |
| mem_valid | output | 1 | Forwarded access valid toward the stub memory |
| mem_ready | input | 1 | Stub memory accepts the forwarded access |
| mem_write | output | 1 | Forwarded access direction |
| mem_addr | output | 24 | Forwarded access address |
| sd_clk_en | output | 1 | SDRAM clock enable, set by the first NOP |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address of the command |
| sd_a | output | 12 | Address/payload lines of the command |

## Verification
The hardest case to reach from the ports is a refresh firing while a normal-mode write is waiting. The write must be stalled in exactly that cycle and not in the cycles around it. The stimulus writes a short refresh interval while the mode is 1, so the timer stays held, and then writes mode 0 at a known edge. From that edge the bench computes every refresh cycle. It keeps a normal write valid, with the memory ready, across the first refresh, and samples the handshake in the cycle before the refresh and in the firing cycle itself. Rejected load-mode writes, caused by wrong bank bits, are the second blind spot. The bench sends them between good ones and checks the bus stays deselected.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  // Command mode held in the control register
  typedef enum logic [2:0] {
    MD_NORMAL  = 3'd0,
    MD_NOP     = 3'd1,
    MD_PRECH   = 3'd2,
    MD_LMR     = 3'd3,
    MD_AREF    = 3'd4,
    MD_XLMR    = 3'd5,
    MD_RSV6    = 3'd6,
    MD_RSV7    = 3'd7
  } mode_e;

  // Command bus encoding {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_NOP   = 4'b0111,
    CMD_PRE   = 4'b0010,
    CMD_AREF  = 4'b0001,
    CMD_LMR   = 4'b0000
  } cmd_e;

endpackage

// File: rtl/sdcmd_addr_split.sv
// Splits the row/bank part of an access address into its fields.
module sdcmd_addr_split #(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2
) (
  input  logic [ROW_W+BANK_W-1:0] upper,
  output logic [ROW_W-1:0]        row,
  output logic [BANK_W-1:0]       bank
);
  assign row  = upper[ROW_W-1:0];
  assign bank = upper[ROW_W+BANK_W-1:ROW_W];
endmodule

// File: rtl/sdcmd_decode.sv
// Maps the armed mode plus the trigger address onto one command.
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2
) (
  input  mode_e             mode,
  input  logic [ROW_W-1:0]  row,
  input  logic [BANK_W-1:0] bank,
  output logic              ok,
  output cmd_e              code,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  a
);
  localparam logic [ROW_W-1:0]  A10_SET  = ROW_W'(1) << 10;
  localparam logic [BANK_W-1:0] LMR_BA   = '0;
  localparam logic [BANK_W-1:0] XLMR_BA  = BANK_W'(2);

  always_comb begin
    ok   = 1'b0;
    code = CMD_DESEL;
    ba   = '0;
    a    = '0;
    unique case (mode)
      MD_NOP: begin
        ok   = 1'b1;
        code = CMD_NOP;
      end
      MD_PRECH: begin
        ok   = 1'b1;
        code = CMD_PRE;
        a    = A10_SET;
      end
      MD_AREF: begin
        ok   = 1'b1;
        code = CMD_AREF;
      end
      MD_LMR: begin
        ok   = (bank == LMR_BA);
        code = CMD_LMR;
        ba   = bank;
        a    = row;
      end
      MD_XLMR: begin
        ok   = (bank == XLMR_BA);
        code = CMD_LMR;
        ba   = bank;
        a    = row;
      end
      default: begin
        ok   = 1'b0;
        code = CMD_DESEL;
      end
    endcase
  end
endmodule

// File: rtl/sdcmd_refresh_timer.sv
// Interval register plus down-counter that pulses a refresh request.
module sdcmd_refresh_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             enable,
  output logic             fire
);
  logic [CNT_W-1:0] interval_q;
  logic [CNT_W-1:0] tmr_q;
  logic             run;

  function automatic logic [CNT_W-1:0] reload(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction

  assign run  = enable && (interval_q != '0);
  assign fire = run && (tmr_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      interval_q <= '0;
      tmr_q      <= '0;
    end else if (load) begin
      interval_q <= load_val;
      tmr_q      <= reload(load_val);
    end else if (!run || tmr_q == '0) begin
      tmr_q <= reload(interval_q);
    end else begin
      tmr_q <= tmr_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/sdcmd_cmd_reg.sv
// Registered command bus and sticky SDRAM clock enable.
module sdcmd_cmd_reg
  import sdcmd_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  cmd_e              code,
  input  logic [BANK_W-1:0] ba_in,
  input  logic [ROW_W-1:0]  a_in,
  output logic [3:0]        cmd_bus,
  output logic [BANK_W-1:0] ba_out,
  output logic [ROW_W-1:0]  a_out,
  output logic              clk_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_bus <= CMD_DESEL;
      ba_out  <= '0;
      a_out   <= '0;
      clk_en  <= 1'b0;
    end else begin
      cmd_bus <= issue ? code  : CMD_DESEL;
      ba_out  <= issue ? ba_in : '0;
      a_out   <= issue ? a_in  : '0;
      if (issue && code == CMD_NOP) clk_en <= 1'b1;
    end
  end
endmodule

// File: rtl/sdcmd_issuer.sv
module sdcmd_issuer
  import sdcmd_pkg::*;
#(
  parameter int BYTE_W = 1,
  parameter int COL_W  = 9,
  parameter int ROW_W  = 12,
  parameter int BANK_W = 2,
  parameter int CFG_W  = 16,
  localparam int LOW_W  = BYTE_W + COL_W,
  localparam int ADDR_W = LOW_W + ROW_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              sd_clk_en,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ROW_W-1:0]  sd_a
);
  mode_e             mode_q;
  logic              ref_fire;
  logic              cmd_path;
  logic              wr_take;
  logic [ROW_W-1:0]  row_f;
  logic [BANK_W-1:0] bank_f;
  logic              dec_ok;
  cmd_e              dec_code;
  logic [BANK_W-1:0] dec_ba;
  logic [ROW_W-1:0]  dec_a;
  logic              issue;
  cmd_e              issue_code;
  logic [BANK_W-1:0] issue_ba;
  logic [ROW_W-1:0]  issue_a;
  logic [3:0]        cmd_bus;

  // Mode register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 mode_q <= MD_NORMAL;
    else if (cfg_we && !cfg_sel) mode_q <= mode_e'(cfg_wdata[2:0]);
  end

  sdcmd_refresh_timer #(.CNT_W(CFG_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_we && cfg_sel),
    .load_val (cfg_wdata),
    .enable   (mode_q == MD_NORMAL),
    .fire     (ref_fire)
  );

  // Access steering: writes in a command mode are consumed here
  assign cmd_path  = acc_write && (mode_q != MD_NORMAL);
  assign acc_ready = !ref_fire && (cmd_path || mem_ready);
  assign mem_valid = acc_valid && !cmd_path && !ref_fire;
  assign mem_write = acc_write;
  assign mem_addr  = acc_addr;
  assign wr_take   = acc_valid && acc_ready && cmd_path;

  sdcmd_addr_split #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_split (
    .upper (acc_addr[ADDR_W-1:LOW_W]),
    .row   (row_f),
    .bank  (bank_f)
  );

  sdcmd_decode #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_dec (
    .mode (mode_q),
    .row  (row_f),
    .bank (bank_f),
    .ok   (dec_ok),
    .code (dec_code),
    .ba   (dec_ba),
    .a    (dec_a)
  );

  // Refresh and software commands never coincide: refresh needs mode 0
  assign issue      = ref_fire || (wr_take && dec_ok);
  assign issue_code = ref_fire ? CMD_AREF : dec_code;
  assign issue_ba   = ref_fire ? '0 : dec_ba;
  assign issue_a    = ref_fire ? '0 : dec_a;

  sdcmd_cmd_reg #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .issue   (issue),
    .code    (issue_code),
    .ba_in   (issue_ba),
    .a_in    (issue_a),
    .cmd_bus (cmd_bus),
    .ba_out  (sd_ba),
    .a_out   (sd_a),
    .clk_en  (sd_clk_en)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_bus;
endmodule

// File: rtl/sdcmd_issuer_chk.sv
module sdcmd_issuer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_valid,
  input logic       acc_ready,
  input logic       acc_write,
  input logic       mem_valid,
  input logic       sd_clk_en,
  input logic       sd_cs_n,
  input logic       sd_ras_n,
  input logic       sd_cas_n,
  input logic       sd_we_n,
  input logic       sd_a10,
  input logic [2:0] mode,
  input logic       ref_fire
);
  logic       take_wr;
  logic [3:0] bus;
  assign take_wr = acc_valid && acc_ready && acc_write;
  assign bus     = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  // R3
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_wr && (mode == 3'd1 || mode == 3'd2 || mode == 3'd4)) |=> !sd_cs_n);

  // R12
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_wr && mode >= 3'd6) |=> sd_cs_n);

  // R5
  clk_en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sd_clk_en |=> sd_clk_en);

  // R5
  clk_en_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sd_clk_en) |-> (bus == 4'b0111));

  // R8
  no_mem_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mode == 3'd0 || !acc_write));

  // R11
  refresh_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |-> (!acc_ready && !mem_valid));

  // R10
  refresh_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fire |=> (bus == 4'b0001));

  // R2
  pre_a10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus == 4'b0010) |-> sd_a10);
endmodule

bind sdcmd_issuer sdcmd_issuer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_ready (acc_ready),
  .acc_write (acc_write),
  .mem_valid (mem_valid),
  .sd_clk_en (sd_clk_en),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_a10    (sd_a[10]),
  .mode      (mode_q),
  .ref_fire  (ref_fire)
);

// File: tb/sim_sdcmd_issuer.sv
module sim_sdcmd_issuer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic        acc_write = 1'b0;
  logic [23:0] acc_addr = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b0;
  logic        mem_write;
  logic [23:0] mem_addr;
  logic        sd_clk_en, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0]  sd_ba;
  logic [11:0] sd_a;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    logic [3:0]  code;
    logic [1:0]  ba;
    logic [11:0] a;
    int          at;
    string       req;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdcmd_issuer u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Monitor: every command cycle on the bus must match the next queued item
  always @(negedge clk) begin
    if (rst_n && !sd_cs_n) begin
      if (q.size() == 0) begin
        chk(0, "R3 unexpected command", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'hF);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == e.code, {e.req, " code"},
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, e.code);
        chk(sd_ba == e.ba, {e.req, " bank"}, sd_ba, e.ba);
        chk(sd_a == e.a, {e.req, " addr"}, sd_a, e.a);
        if (e.at >= 0) chk(cyc == e.at, {e.req, " cycle"}, cyc, e.at);
      end
    end
  end

  task automatic push(input logic [3:0] code, input logic [1:0] ba,
                      input logic [11:0] a, input int at, input string req);
    exp_t e;
    e.code = code; e.ba = ba; e.a = a; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic cfg_write(input bit sel, input logic [15:0] val, output int k);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    k = cyc;
  endtask

  // Driver: command-mode write, expected result pushed to the scoreboard
  task automatic cmd_write(input logic [23:0] addr, input bit fires, input logic [3:0] code,
                           input logic [1:0] ba, input logic [11:0] a, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = addr;
    if (fires) push(code, ba, a, -1, req);
    #1;
    chk(acc_ready == 1'b1 && mem_valid == 1'b0, {req, " R3 accept"}, {acc_ready, mem_valid}, 2'b10);
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    if (!fires) begin
      #1;
      chk(sd_cs_n == 1'b1, {req, " no command"}, sd_cs_n, 1);
    end
  endtask

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'hF, "R1 bus idle",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'hF);
    chk(sd_clk_en == 1'b0, "R1 clk_en", sd_clk_en, 0);
    chk(mem_valid == 1'b0, "R1 mem_valid", mem_valid, 0);

    // R8 forwarded write in mode 0, with memory back-pressure
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 24'h123456; mem_ready = 1'b0;
    #1;
    chk(mem_valid && !acc_ready && mem_addr == 24'h123456 && mem_write,
        "R8 stalled forward", {mem_valid, acc_ready}, 2'b10);
    mem_ready = 1'b1;
    #1;
    chk(acc_ready == 1'b1, "R8 ready follows memory", acc_ready, 1);
    @(negedge clk);
    acc_valid = 1'b0;

    // R9 read in command mode is forwarded; R5 clock still off
    cfg_write(1'b0, 16'd1, k);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 24'h0000AA;
    #1;
    chk(mem_valid && acc_ready && !mem_write, "R9 read forwarded", {mem_valid, acc_ready}, 2'b11);
    @(negedge clk);
    acc_valid = 1'b0;
    #1;
    chk(sd_clk_en == 1'b0, "R5 clk_en before NOP", sd_clk_en, 0);

    // R2 R5 NOP turns the SDRAM clock on
    cmd_write(24'h001234, 1, 4'b0111, 2'b00, 12'h000, "R2 NOP");
    #1;
    chk(sd_clk_en == 1'b1, "R5 clk_en after NOP", sd_clk_en, 1);

    // R2 precharge all with A10
    cfg_write(1'b0, 16'd2, k);
    cmd_write(24'h400000, 1, 4'b0010, 2'b00, 12'h400, "R2 precharge");

    // R4 two auto-refresh commands from two writes
    cfg_write(1'b0, 16'd4, k);
    cmd_write(24'h000010, 1, 4'b0001, 2'b00, 12'h000, "R4 refresh 1");
    cmd_write(24'hFFFFFE, 1, 4'b0001, 2'b00, 12'h000, "R4 refresh 2");

    // R6 R7 extended load-mode: bank 10 from offset 0x800000, row 0x020
    cfg_write(1'b0, 16'd5, k);
    cmd_write(24'h808000, 1, 4'b0000, 2'b10, 12'h020, "R7 ext load-mode");
    cmd_write(24'h408000, 0, 4'b0000, 2'b00, 12'h000, "R6 ext bad bank");

    // R6 load-mode: bank 00, row 0x032
    cfg_write(1'b0, 16'd3, k);
    cmd_write(24'h00C800, 1, 4'b0000, 2'b00, 12'h032, "R6 load-mode");
    cmd_write(24'hC0C800, 0, 4'b0000, 2'b00, 12'h000, "R6 load-mode bad bank");

    // R12 reserved modes
    cfg_write(1'b0, 16'd6, k);
    cmd_write(24'h000100, 0, 4'b0000, 2'b00, 12'h000, "R12 mode 6");
    cfg_write(1'b0, 16'd7, k);
    cmd_write(24'h000100, 0, 4'b0000, 2'b00, 12'h000, "R12 mode 7");

    // R5 second NOP keeps the clock on
    cfg_write(1'b0, 16'd1, k);
    cmd_write(24'h000000, 1, 4'b0111, 2'b00, 12'h000, "R5 second NOP");
    chk(sd_clk_en == 1'b1, "R5 clk_en stays", sd_clk_en, 1);

    // R10 interval set in a nonzero mode: no refresh
    cfg_write(1'b1, 16'd10, k);
    repeat (25) @(negedge clk);
    chk(q.size() == 0, "R10 idle in mode 1", q.size(), 0);

    // R10 R11 mode 0 starts the timer at a known edge
    cfg_write(1'b0, 16'd0, k);
    push(4'b0001, 2'b00, 12'h000, k + 10, "R10 timed refresh 1");
    push(4'b0001, 2'b00, 12'h000, k + 20, "R10 timed refresh 2");
    push(4'b0001, 2'b00, 12'h000, k + 30, "R10 timed refresh 3");
    acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 24'h000200; mem_ready = 1'b1;
    while (cyc != k + 8) @(negedge clk);
    #1;
    chk(acc_ready == 1'b1, "R11 ready before refresh", acc_ready, 1);
    @(negedge clk);
    #1;
    chk(acc_ready == 1'b0 && mem_valid == 1'b0, "R11 stall on refresh",
        {acc_ready, mem_valid}, 2'b00);
    @(negedge clk);
    acc_valid = 1'b0;
    while (cyc < k + 30) @(negedge clk);
    #1;
    chk(q.size() == 0, "R10 all refreshes seen", q.size(), 0);

    // R10 interval zero stops refresh
    cfg_write(1'b1, 16'd0, k);
    repeat (40) @(negedge clk);
    chk(q.size() == 0, "R10 zero interval", q.size(), 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule